// File: doc/BRIEF.md
# Keyed Watchdog Reset Timer

This block is a watchdog that can pull the chip into reset by itself. It holds three writable registers: a key register, a 32-bit count register and an enable register. The count and enable registers are guarded by the key. A write to either one lands only while the key register holds the unlock value 0x482E. Any other value written to the key register locks the block again.

Once count-enable is set, the count register falls by one on each clock until it reaches zero. If reset-enable is also set when the count reaches zero, the block drives a reset request pulse of a fixed length, `PULSE_CYC` clocks. An immediate reset needs no waiting: unlock the block, write a count of zero, then set both enable bits.

Each arming gives one pulse. The block is rearmed by an accepted write to the count or enable register. Writes arrive through a plain single-cycle strobe with no back-pressure, so every strobed write is taken in the cycle it is presented. There is no stream data path, so no valid/ready handshake applies. The current key state, count and enable bits are visible on output pins.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the count is 0, both enable bits are 0, the block is locked and the reset request is low.
- R2: The block is unlocked exactly when the last value written to the key register, taken from `wr_data[15:0]`, equals 0x482E. Writing any other value locks it from the next cycle.
- R3: A write to the count register (`wr_sel`=1) while locked is dropped and leaves the count unchanged.
- R4: A write to the enable register (`wr_sel`=2) while locked is dropped and leaves both enable bits unchanged.
- R5: In an accepted enable write, `wr_data[0]` sets reset-enable and `wr_data[2]` sets count-enable. All other data bits are ignored.
- R6: While count-enable is set, the count drops by one each clock and holds at zero. While count-enable is clear, the count holds. An accepted count write loads `wr_data` in place of the decrement.
- R7: When the registered count is 0 and both enable bits are set, `rst_req_o` rises in the next cycle and stays high for exactly `PULSE_CYC` cycles (default 4).
- R8: With reset-enable clear, a count at zero never raises `rst_req_o`.
- R9: Unlocking, writing a count of 0 and then writing 0x5 to the enable register raises `rst_req_o` one cycle after the enable write takes effect.
- R10: Only one pulse is produced per arming. A later accepted write to the count or enable register rearms the block, so an expired state fires again.
- R11: Writes to the key register (`wr_sel`=0) are always accepted. Select value 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 2 | Register select: 0 key, 1 count, 2 enable, 3 none |
| wr_data | input | 32 | Write data |
| unlocked_o | output | 1 | Key register holds the unlock value |
| count_o | output | 32 | Current count |
| rst_en_o | output | 1 | Reset-enable bit |
| cnt_en_o | output | 1 | Count-enable bit |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The assertions assume a write is held for only one cycle and that `wr_sel` is never unknown while `wr_en` is high. The stall checks on the count also assume no accepted count write arrives in the same cycle as a locked one, which cannot happen with a single write port. The stimulus drives one write or an idle cycle per clock from a task, always with a defined select value. It reaches the expiry states both by counting down and by a direct zero load. It also crosses every lock transition with writes that must be dropped.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  typedef enum logic [1:0] {
    SEL_KEY    = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } wdt_sel_e;

  localparam int unsigned KEY_W       = 16;
  localparam logic [15:0] UNLOCK_KEY  = 16'h482E;
  localparam int unsigned RSTEN_POS   = 0;
  localparam int unsigned CNTEN_POS   = 2;
endpackage

// File: rtl/wdt_lock.sv
module wdt_lock #(
  parameter int unsigned KW = 16,
  parameter logic [KW-1:0] KEY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_we,
  input  logic [KW-1:0] key_din,
  output logic [KW-1:0] key_q,
  output logic          unlocked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= '0;
    else if (key_we) key_q <= key_din;
  end

  assign unlocked = (key_q == KEY);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic [CW-1:0] count,
  output logic          at_zero
);
  assign at_zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (load)             count <= load_val;
    else if (run && !at_zero)  count <= count - 1'b1;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic expired,
  output logic pulse
);
  localparam int unsigned PW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_CYC);

  logic [PW-1:0] left_q;
  logic          fired_q;
  logic          fire;

  assign fire  = expired && (left_q == '0) && !fired_q;
  assign pulse = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      fired_q <= 1'b0;
    end else begin
      if (fire)             left_q <= PLEN;
      else if (left_q != 0) left_q <= left_q - 1'b1;
      if (rearm)            fired_q <= 1'b0;
      else if (fire)        fired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             unlocked_o,
  output logic [CNT_W-1:0] count_o,
  output logic             rst_en_o,
  output logic             cnt_en_o,
  output logic             rst_req_o
);
  logic [KEY_W-1:0] key_q;
  logic             unlocked;
  logic             cnt_wr, en_wr, at_zero;
  logic             rst_en_q, cnt_en_q;

  assign cnt_wr = wr_en && (wdt_sel_e'(wr_sel) == SEL_COUNT)  && unlocked;
  assign en_wr  = wr_en && (wdt_sel_e'(wr_sel) == SEL_ENABLE) && unlocked;

  wdt_lock #(.KW(KEY_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (wr_en && (wdt_sel_e'(wr_sel) == SEL_KEY)),
    .key_din  (wr_data[KEY_W-1:0]),
    .key_q    (key_q),
    .unlocked (unlocked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_en_q <= 1'b0;
      cnt_en_q <= 1'b0;
    end else if (en_wr) begin
      rst_en_q <= wr_data[RSTEN_POS];
      cnt_en_q <= wr_data[CNTEN_POS];
    end
  end

  wdt_counter #(.CW(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_wr),
    .load_val (wr_data),
    .run      (cnt_en_q),
    .count    (count_o),
    .at_zero  (at_zero)
  );

  wdt_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .rearm   (cnt_wr || en_wr),
    .expired (at_zero && cnt_en_q && rst_en_q),
    .pulse   (rst_req_o)
  );

  assign unlocked_o = unlocked;
  assign rst_en_o   = rst_en_q;
  assign cnt_en_o   = cnt_en_q;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PULSE_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             unlocked_o,
  input logic [CNT_W-1:0] count_o,
  input logic             rst_en_o,
  input logic             cnt_en_o,
  input logic             rst_req_o
);
  int unsigned run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= 0;
    else if (rst_req_o) run_len <= run_len + 1;
    else                run_len <= 0;
  end

  // R2
  a_r2_wrong_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data[15:0] != 16'h482E) |=> !unlocked_o);

  // R3
  a_r3_locked_count_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && !unlocked_o && !cnt_en_o) |=> $stable(count_o));

  // R4
  a_r4_locked_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && !unlocked_o) |=> ($stable(rst_en_o) && $stable(cnt_en_o)));

  // R6
  a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_o && count_o != '0 && !(wr_en && wr_sel == 2'd1 && unlocked_o))
      |=> count_o == $past(count_o) - 1'b1);

  // R7, R8
  a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> ($past(count_o) == '0 && $past(cnt_en_o) && $past(rst_en_o)));

  // R7
  a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_o) |-> run_len == PULSE_CYC);
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .unlocked_o(unlocked_o), .count_o(count_o), .rst_en_o(rst_en_o),
  .cnt_en_o(cnt_en_o), .rst_req_o(rst_req_o)
);

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
  localparam int PULSE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        unlocked_o, rst_en_o, cnt_en_o, rst_req_o;
  logic [31:0] count_o;

  always #2.5 clk = ~clk;

  keyed_wdt #(.CNT_W(32), .PULSE_CYC(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .unlocked_o(unlocked_o), .count_o(count_o), .rst_en_o(rst_en_o),
    .cnt_en_o(cnt_en_o), .rst_req_o(rst_req_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int unsigned m_key = 0, m_cnt = 0, m_left = 0;
  bit m_rsten = 0, m_cnten = 0, m_fired = 0;

  task automatic check(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    check(req, "unlocked", unlocked_o, (m_key == 32'h482E));
    check(req, "count", count_o, m_cnt);
    check(req, "rst_en", rst_en_o, m_rsten);
    check(req, "cnt_en", cnt_en_o, m_cnten);
    check(req, "rst_req", rst_req_o, (m_left != 0));
  endtask

  task automatic step(bit we, int sel, int unsigned d, string req);
    bit unl, cw, ew, fire;
    @(negedge clk);
    wr_en = we; wr_sel = sel[1:0]; wr_data = d;
    @(posedge clk);
    #1;
    unl  = (m_key == 32'h482E);
    cw   = we && sel == 1 && unl;
    ew   = we && sel == 2 && unl;
    fire = m_cnten && m_rsten && m_cnt == 0 && m_left == 0 && !m_fired;
    if (fire) m_left = PULSE; else if (m_left != 0) m_left--;
    if (cw || ew) m_fired = 0; else if (fire) m_fired = 1;
    if (cw) m_cnt = d; else if (m_cnten && m_cnt != 0) m_cnt--;
    if (ew) begin m_rsten = d[0]; m_cnten = d[2]; end
    if (we && sel == 0) m_key = d & 32'hFFFF;
    compare_all(req);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) step(0, 0, 0, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; compare_all("R1");
    @(negedge clk); rst_n = 1'b1;
    idle(2, "R1");
    // locked writes are dropped
    step(1, 1, 100, "R3"); idle(1, "R3");
    step(1, 2, 5, "R4");   idle(2, "R4");
    // wrong key stays locked
    step(1, 0, 32'h1234, "R2"); step(1, 1, 77, "R3");
    // unlock; key upper bits ignored
    step(1, 0, 32'hABCD482E, "R2");
    step(1, 1, 10, "R6");
    step(1, 2, 32'h4, "R5");
    idle(15, "R8");           // runs to zero, holds, no reset
    step(1, 2, 32'hFFFFFFFA, "R5"); idle(1, "R5");
    step(1, 1, 0, "R9");
    step(1, 2, 5, "R9");
    idle(PULSE + 4, "R9");    // one pulse then no refire
    idle(3, "R10");
    step(1, 2, 5, "R10");     // rearm
    idle(PULSE + 3, "R10");
    step(1, 1, 6, "R7");
    idle(PULSE + 10, "R7");
    step(1, 3, 32'hFFFF, "R11"); idle(1, "R11");
    step(1, 0, 0, "R2");      // relock
    step(1, 2, 0, "R4"); step(1, 1, 3, "R3");
    idle(PULSE + 3, "R10");
    step(1, 0, 32'h482E, "R11");
    step(1, 2, 1, "R6");      // reset-enable only, count held
    step(1, 1, 9, "R6");
    idle(4, "R6");
    step(1, 2, 4, "R6");
    idle(12, "R7");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule